// File: doc/BRIEF.md
# IN Endpoint Transmit Responder

This block serves the transmit side of a single USB device IN endpoint. A DMA engine pours packet bytes into a private transmit buffer that belongs to this endpoint alone. The host may poll endpoints in any order. When the token decoder reports an IN token for the endpoint, the block first decides whether a packet is ready to go. If none is ready, it answers with a NAK handshake request and raises an interrupt. If one is ready, it streams the data bytes and then a CRC16 to the packet transmitter, and waits for the host's handshake.

An acknowledged packet is freed from the buffer, the DATA0/DATA1 toggle advances, and a completion interrupt fires. A packet that gets no handshake stays in the buffer untouched, and the next IN token resends it. If the buffer runs dry while a packet is on the wire, the block sends the CRC bit-inverted. The host then rejects the packet, and the data that was already buffered remains for the retry.

Top module: `in_ep_tx`

## Requirements
- R1: After reset, tx_valid, tx_last, tx_nak, irq_nak and irq_done are low, and tx_data1 is 0 (DATA0).
- R2: An IN token that finds no ready packet produces exactly one single-cycle tx_nak pulse and one single-cycle irq_nak pulse, and sends no data byte.
- R3: While ep_enable is low, IN tokens cause no data, no NAK and no interrupt, and the buffered packet is kept for later.
- R4: A packet is ready when the unacknowledged byte count is at least max_pkt_len, or when a writer end mark is pending, or (only when EARLY_LEVEL is nonzero) when the count reaches EARLY_LEVEL. Without an end mark, the packet sent is max_pkt_len bytes long.
- R5: The data bytes go out in write order. They are followed by two CRC bytes, low byte first, and tx_last is high on the second. The CRC uses the reflected polynomial x^16+x^15+x^2+1, starts from 0xFFFF, runs over the data bytes LSB first, and is sent complemented.
- R6: tx_data1 changes only after an acknowledged packet, and then it flips.
- R7: If no hs_ack arrives within TIMEOUT cycles after the last CRC byte, the packet is kept. The next token resends the same bytes with the same tx_data1, and no irq_done fires.
- R8: Each hs_ack received while awaiting a handshake yields exactly one single-cycle irq_done pulse, two cycles later.
- R9: A byte written with wr_last high ends a short packet. That packet is ready at once and its length is the byte count up to and including the marked byte.
- R10: If the transmitter requests a byte (tx_ready high) while the buffer holds none, the packet ends at once. The two CRC bytes then carry the uncomplemented CRC register over the bytes already sent, and those bytes stay buffered.
- R11: An IN token arriving while a packet is in flight or awaiting its handshake is ignored.
- R12: While tx_ready is low, the presented byte is held and not consumed.
- R13: A write is dropped while the buffer holds DEPTH unacknowledged bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_enable | input | 1 | Endpoint enable; gates token acceptance |
| max_pkt_len | input | LEN_W | Programmed full packet length in bytes (at least 1) |
| wr_en | input | 1 | Buffer write strobe from DMA |
| wr_data | input | 8 | Byte to write |
| wr_last | input | 1 | Marks the written byte as the end of a short packet |
| in_token | input | 1 | One-cycle IN token for this endpoint |
| hs_ack | input | 1 | One-cycle host ACK handshake |
| tx_ready | input | 1 | Packet transmitter takes the presented byte |
| tx_valid | output | 1 | A data or CRC byte is presented |
| tx_data | output | 8 | Presented byte |
| tx_last | output | 1 | Presented byte is the final CRC byte |
| tx_data1 | output | 1 | Data PID to use: 0 for DATA0, 1 for DATA1 |
| tx_nak | output | 1 | One-cycle request to send a NAK handshake |
| irq_nak | output | 1 | One-cycle interrupt: token found no packet |
| irq_done | output | 1 | One-cycle interrupt: packet acknowledged |

## Verification
Two collisions are provoked. In the first, an IN token lands while the endpoint is still waiting for the handshake of the previous packet. The bench pulses the token in that window and then acknowledges. It judges the result by the absence of any extra NAK or extra data bytes and by a single completion interrupt. In the second, the transmitter pulls a byte in the very cycle the buffer runs dry. The bench starts a long packet with only part of it buffered, checks that the CRC bytes match the uncomplemented register value computed in the bench, and then refills the buffer to confirm that the retry delivers the complete, correctly checked packet.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_SEND_DATA,
      ST_SEND_CRC,
      ST_WAIT_HS,
      ST_DONE
   } ep_state_t;

   localparam logic [15:0] CRC_SEED      = 16'hFFFF;
   localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

   // One byte through the reflected CRC16, least significant bit first.
   function automatic logic [15:0] crc16_step(input logic [15:0] acc, input logic [7:0] din);
      logic [15:0] c;
      logic        fb;
      c = acc;
      for (int b = 0; b < 8; b++) begin
         fb = c[0] ^ din[b];
         c  = c >> 1;
         if (fb) c = c ^ CRC_POLY_REFL;
      end
      return c;
   endfunction

endpackage

// File: rtl/in_ep_txbuf.sv
module in_ep_txbuf #(
   parameter int DEPTH       = 64,
   parameter int EARLY_LEVEL = 0,
   parameter int LEN_W       = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             wr_last,
   input  logic [LEN_W-1:0] max_len,
   input  logic             rd_restart,
   input  logic             rd_adv,
   input  logic             commit,
   output logic [7:0]       rd_data,
   output logic             rd_avail,
   output logic             pkt_ready,
   output logic [LEN_W-1:0] pkt_len
);
   localparam int AW = $clog2(DEPTH);

   logic [7:0]       mem [DEPTH];
   logic [LEN_W-1:0] wr_p, rd_p, base_p, base_nxt, fill;
   logic [LEN_W-1:0] mark_len;
   logic             mark_vld, wr_ok, full_ok, early_ok;

   assign fill     = wr_p - base_p;
   assign wr_ok    = wr_en && (fill != LEN_W'(DEPTH));
   assign base_nxt = commit ? rd_p : base_p;
   assign rd_data  = mem[rd_p[AW-1:0]];
   assign rd_avail = (rd_p != wr_p);
   assign full_ok  = (fill >= max_len);

   generate
      if (EARLY_LEVEL == 0) begin : g_whole_packet
         assign early_ok = 1'b0;
      end else begin : g_early_start
         assign early_ok = (fill >= LEN_W'(EARLY_LEVEL));
      end
   endgenerate

   assign pkt_ready = full_ok || mark_vld || early_ok;
   assign pkt_len   = (mark_vld && (mark_len < max_len)) ? mark_len : max_len;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_p[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_p     <= '0;
         rd_p     <= '0;
         base_p   <= '0;
         mark_vld <= 1'b0;
         mark_len <= '0;
      end else begin
         if (wr_ok) wr_p <= wr_p + LEN_W'(1);
         if (rd_restart)  rd_p <= base_p;
         else if (rd_adv) rd_p <= rd_p + LEN_W'(1);
         base_p <= base_nxt;
         if (wr_ok && wr_last) begin
            mark_vld <= 1'b1;
            mark_len <= wr_p + LEN_W'(1) - base_nxt;
         end else if (commit) begin
            mark_vld <= 1'b0;
         end
      end
   end

   assert_fill_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= LEN_W'(DEPTH));

   assert_read_window_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_p - base_p) <= fill);

endmodule

// File: rtl/in_ep_crc16.sv
module in_ep_crc16 (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   import in_ep_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc <= CRC_SEED;
      else if (init) crc <= CRC_SEED;
      else if (en)   crc <= crc16_step(crc, din);
   end

endmodule

// File: rtl/in_ep_ctrl.sv
module in_ep_ctrl #(
   parameter int LEN_W   = 7,
   parameter int TIMEOUT = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ep_enable,
   input  logic             in_token,
   input  logic             hs_ack,
   input  logic             tx_ready,
   input  logic             pkt_ready,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             rd_avail,
   input  logic [7:0]       rd_data,
   input  logic [15:0]      crc,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_last,
   output logic             tx_data1,
   output logic             tx_nak,
   output logic             irq_nak,
   output logic             irq_done,
   output logic             rd_restart,
   output logic             rd_adv,
   output logic             commit,
   output logic             crc_init,
   output logic             crc_en
);
   import in_ep_pkg::*;

   localparam int TMR_W = $clog2(TIMEOUT);

   ep_state_t        st;
   logic [LEN_W-1:0] send_len, cnt;
   logic [TMR_W-1:0] timer;
   logic             bad, crc_hi, data1;
   logic [15:0]      crc_word;

   assign crc_word = ~crc ^ {16{bad}};
   assign tx_data1 = data1;

   always_comb begin
      tx_valid   = 1'b0;
      tx_data    = '0;
      tx_last    = 1'b0;
      rd_adv     = 1'b0;
      crc_en     = 1'b0;
      rd_restart = (st == ST_CHECK) && pkt_ready;
      crc_init   = (st == ST_CHECK) && pkt_ready;
      commit     = (st == ST_DONE);
      case (st)
         ST_SEND_DATA: begin
            tx_valid = rd_avail;
            tx_data  = rd_data;
            rd_adv   = rd_avail && tx_ready;
            crc_en   = rd_avail && tx_ready;
         end
         ST_SEND_CRC: begin
            tx_valid = 1'b1;
            tx_data  = crc_hi ? crc_word[15:8] : crc_word[7:0];
            tx_last  = crc_hi;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         send_len <= '0;
         cnt      <= '0;
         timer    <= '0;
         bad      <= 1'b0;
         crc_hi   <= 1'b0;
         data1    <= 1'b0;
         tx_nak   <= 1'b0;
         irq_nak  <= 1'b0;
         irq_done <= 1'b0;
      end else begin
         tx_nak   <= 1'b0;
         irq_nak  <= 1'b0;
         irq_done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (in_token && ep_enable) st <= ST_CHECK;
            end
            ST_CHECK: begin
               if (pkt_ready) begin
                  send_len <= pkt_len;
                  cnt      <= '0;
                  bad      <= 1'b0;
                  st       <= ST_SEND_DATA;
               end else begin
                  tx_nak  <= 1'b1;
                  irq_nak <= 1'b1;
                  st      <= ST_IDLE;
               end
            end
            ST_SEND_DATA: begin
               if (tx_ready) begin
                  if (!rd_avail) begin
                     bad    <= 1'b1;
                     crc_hi <= 1'b0;
                     st     <= ST_SEND_CRC;
                  end else begin
                     cnt <= cnt + LEN_W'(1);
                     if (cnt == send_len - LEN_W'(1)) begin
                        crc_hi <= 1'b0;
                        st     <= ST_SEND_CRC;
                     end
                  end
               end
            end
            ST_SEND_CRC: begin
               if (tx_ready) begin
                  if (crc_hi) begin
                     timer <= '0;
                     st    <= ST_WAIT_HS;
                  end else begin
                     crc_hi <= 1'b1;
                  end
               end
            end
            ST_WAIT_HS: begin
               if (hs_ack)                            st <= ST_DONE;
               else if (timer == TMR_W'(TIMEOUT - 1)) st <= ST_IDLE;
               else                                   timer <= timer + TMR_W'(1);
            end
            ST_DONE: begin
               data1    <= ~data1;
               irq_done <= 1'b1;
               st       <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_token_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CHECK) |-> ($past(st) == ST_IDLE));

   assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !ep_enable) |=> (st == ST_IDLE));

   assert_toggle_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data1 != $past(data1)) |-> ($past(st) == ST_DONE));

   assert_underrun_corrupts_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SEND_DATA && tx_ready && !rd_avail) |=> (st == ST_SEND_CRC && bad));

   assert_nak_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_nak |-> (!tx_valid && tx_nak));

   assert_done_follows_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT_HS && hs_ack) |=> ##1 irq_done);

endmodule

// File: rtl/in_ep_tx.sv
module in_ep_tx #(
   parameter int DEPTH       = 64,
   parameter int EARLY_LEVEL = 0,
   parameter int TIMEOUT     = 64,
   localparam int LEN_W      = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ep_enable,
   input  logic [LEN_W-1:0] max_pkt_len,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             wr_last,
   input  logic             in_token,
   input  logic             hs_ack,
   input  logic             tx_ready,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_last,
   output logic             tx_data1,
   output logic             tx_nak,
   output logic             irq_nak,
   output logic             irq_done
);
   initial begin
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 4");
      assert (EARLY_LEVEL >= 0 && EARLY_LEVEL <= DEPTH)
         else $error("EARLY_LEVEL must lie in 0..DEPTH");
      assert (TIMEOUT >= 2)
         else $error("TIMEOUT must be at least 2");
   end

   logic             pkt_ready, rd_avail, rd_restart, rd_adv, commit;
   logic             crc_init, crc_en;
   logic [LEN_W-1:0] pkt_len;
   logic [7:0]       rd_data;
   logic [15:0]      crc;

   in_ep_txbuf #(.DEPTH(DEPTH), .EARLY_LEVEL(EARLY_LEVEL), .LEN_W(LEN_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
      .max_len(max_pkt_len),
      .rd_restart(rd_restart), .rd_adv(rd_adv), .commit(commit),
      .rd_data(rd_data), .rd_avail(rd_avail),
      .pkt_ready(pkt_ready), .pkt_len(pkt_len)
   );

   in_ep_crc16 u_crc (
      .clk(clk), .rst_n(rst_n),
      .init(crc_init), .en(crc_en), .din(rd_data), .crc(crc)
   );

   in_ep_ctrl #(.LEN_W(LEN_W), .TIMEOUT(TIMEOUT)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ep_enable(ep_enable), .in_token(in_token), .hs_ack(hs_ack), .tx_ready(tx_ready),
      .pkt_ready(pkt_ready), .pkt_len(pkt_len), .rd_avail(rd_avail), .rd_data(rd_data),
      .crc(crc),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_data1(tx_data1),
      .tx_nak(tx_nak), .irq_nak(irq_nak), .irq_done(irq_done),
      .rd_restart(rd_restart), .rd_adv(rd_adv), .commit(commit),
      .crc_init(crc_init), .crc_en(crc_en)
   );

endmodule

// File: tb/sim_in_ep_tx.sv
`timescale 1ns/1ps
module sim_in_ep_tx;
   localparam int DEPTH = 16;
   localparam int EARLY = 4;
   localparam int TMO   = 16;
   localparam int LW    = $clog2(DEPTH) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ep_enable = 1'b0;
   logic [LW-1:0] max_pkt_len = LW'(8);
   logic          wr_en = 1'b0, wr_last = 1'b0, in_token = 1'b0, hs_ack = 1'b0;
   logic          tx_ready = 1'b1;
   logic [7:0]    wr_data = '0;
   logic          tx_valid, tx_last, tx_data1, tx_nak, irq_nak, irq_done;
   logic [7:0]    tx_data;

   int total = 0, bad = 0;
   int cap_n = 0, last_cnt = 0, nak_cnt = 0, inak_cnt = 0, done_cnt = 0;
   logic [7:0] cap [64];
   logic       cap_pid;
   bit         throttle = 0, exp_pid = 0, finished = 0;
   int         cyc = 0;

   always #10 clk = ~clk;

   in_ep_tx #(.DEPTH(DEPTH), .EARLY_LEVEL(EARLY), .TIMEOUT(TMO)) u0 (
      .clk(clk), .rst_n(rst_n), .ep_enable(ep_enable), .max_pkt_len(max_pkt_len),
      .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .in_token(in_token),
      .hs_ack(hs_ack), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last), .tx_data1(tx_data1), .tx_nak(tx_nak), .irq_nak(irq_nak),
      .irq_done(irq_done)
   );

   // transmitter model: ready pattern changes on the falling edge
   initial forever begin
      @(negedge clk);
      cyc++;
      tx_ready = !throttle || (cyc % 3 != 0);
   end

   // monitor: samples 1 ns before each rising edge
   always @(negedge clk) begin
      #9;
      if (tx_valid && tx_ready) begin
         if (cap_n < 64) cap[cap_n] = tx_data;
         cap_n++;
         cap_pid = tx_data1;
         if (tx_last) last_cnt++;
      end
      if (tx_nak)   nak_cnt++;
      if (irq_nak)  inak_cnt++;
      if (irq_done) done_cnt++;
   end

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_of(input int start, input int n);
      logic [15:0] c = 16'hFFFF;
      logic [7:0]  d;
      for (int k = 0; k < n; k++) begin
         d = 8'(start + k);
         for (int b = 0; b < 8; b++) begin
            if (c[0] ^ d[b]) c = (c >> 1) ^ 16'hA001;
            else             c = c >> 1;
         end
      end
      return c;
   endfunction

   task automatic write_run(input int start, input int n, input bit mark);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_data = 8'(start + i); wr_last = mark && (i == n - 1);
      end
      @(negedge clk);
      wr_en = 1'b0; wr_last = 1'b0;
   endtask

   task automatic pulse_token();
      @(negedge clk); in_token = 1'b1;
      @(negedge clk); in_token = 1'b0;
   endtask

   task automatic wait_last(input int l0);
      int k = 0;
      while (last_cnt == l0 && k < 300) begin @(negedge clk); k++; end
   endtask

   task automatic transact(input bit ack, input bit poke_token);
      int l0;
      cap_n = 0; l0 = last_cnt;
      pulse_token();
      wait_last(l0);
      if (poke_token) begin
         in_token = 1'b1; @(negedge clk); in_token = 1'b0;
      end
      if (ack) begin
         hs_ack = 1'b1; @(negedge clk); hs_ack = 1'b0;
         repeat (4) @(negedge clk);
      end else begin
         repeat (TMO + 4) @(negedge clk);
      end
   endtask

   task automatic check_pkt(input string tag, input int start, input int n,
                            input bit corrupt, input bit pid);
      logic [15:0] c, w;
      int          errs = 0;
      c = crc_of(start, n);
      w = corrupt ? c : ~c;
      chk(cap_n == n + 2, {tag, " byte count"}, cap_n, n + 2);
      for (int i = 0; i < n; i++) if (cap[i] != 8'(start + i)) errs++;
      chk(errs == 0, {tag, " data bytes"}, errs, 0);
      chk(cap[n] == w[7:0] && cap[n+1] == w[15:8], {tag, " crc bytes"},
          int'({cap[n+1], cap[n]}), int'(w));
      chk(cap_pid == pid, {tag, " data pid"}, int'(cap_pid), int'(pid));
   endtask

   initial begin
      int d0, n0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!tx_valid && !tx_last && !tx_nak && !irq_nak && !irq_done, "R1 outputs idle",
          int'({tx_valid, tx_last, tx_nak, irq_nak, irq_done}), 0);
      chk(tx_data1 == 1'b0, "R1 starts DATA0", int'(tx_data1), 0);

      // R3 disabled endpoint ignores tokens, keeps data
      write_run(8'h10, 8, 0);
      cap_n = 0;
      pulse_token();
      repeat (8) @(negedge clk);
      chk(cap_n == 0 && nak_cnt == 0 && inak_cnt == 0, "R3 disabled silent",
          cap_n + nak_cnt + inak_cnt, 0);
      ep_enable = 1'b1;
      transact(1, 0);
      check_pkt("R3 kept packet", 8'h10, 8, 0, exp_pid); exp_pid ^= 1'b1;

      // R2 token with too few bytes: NAK + interrupt, no data
      write_run(8'h30, 3, 0);
      cap_n = 0;
      pulse_token();
      repeat (8) @(negedge clk);
      chk(nak_cnt == 1 && inak_cnt == 1, "R2 one nak and irq", nak_cnt * 10 + inak_cnt, 11);
      chk(cap_n == 0, "R2 no data on nak", cap_n, 0);
      write_run(8'h33, 5, 0);
      transact(1, 0);
      check_pkt("R4 full after nak", 8'h30, 8, 0, exp_pid); exp_pid ^= 1'b1;

      // R4 R5 R6 R8 R12 sweep of packet lengths, odd lengths throttled
      for (int len = 1; len <= 8; len++) begin
         max_pkt_len = LW'(len);
         throttle = (len % 2 == 1);
         d0 = done_cnt;
         write_run(16 * len, len, 0);
         transact(1, 0);
         check_pkt(throttle ? "R12 R5 throttled" : "R4 R5 sweep", 16 * len, len, 0, exp_pid);
         chk(done_cnt == d0 + 1, "R8 one done per ack", done_cnt - d0, 1);
         exp_pid ^= 1'b1;
         chk(tx_data1 == exp_pid, "R6 toggle after ack", int'(tx_data1), int'(exp_pid));
      end
      throttle = 0;
      max_pkt_len = LW'(8);

      // R9 short packet by end mark
      write_run(8'hC0, 3, 1);
      transact(1, 0);
      check_pkt("R9 short packet", 8'hC0, 3, 0, exp_pid); exp_pid ^= 1'b1;

      // R7 no handshake: resend identical packet
      d0 = done_cnt;
      write_run(8'h50, 8, 0);
      transact(0, 0);
      check_pkt("R7 first try", 8'h50, 8, 0, exp_pid);
      chk(done_cnt == d0 && tx_data1 == exp_pid, "R7 no done no toggle", done_cnt - d0, 0);
      transact(1, 0);
      check_pkt("R7 retry same", 8'h50, 8, 0, exp_pid); exp_pid ^= 1'b1;

      // R11 token during handshake wait is ignored
      n0 = nak_cnt; d0 = done_cnt;
      write_run(8'h60, 8, 0);
      transact(1, 1);
      check_pkt("R11 packet", 8'h60, 8, 0, exp_pid); exp_pid ^= 1'b1;
      chk(nak_cnt == n0 && done_cnt == d0 + 1 && cap_n == 10, "R11 token ignored",
          (nak_cnt - n0) * 100 + cap_n, 10);

      // R10 underrun: early start with half a packet
      write_run(8'h70, 4, 0);
      transact(0, 0);
      check_pkt("R10 underrun crc", 8'h70, 4, 1, exp_pid);
      write_run(8'h74, 4, 0);
      transact(1, 0);
      check_pkt("R10 retry full", 8'h70, 8, 0, exp_pid); exp_pid ^= 1'b1;

      // R13 overflow: 20 writes, only 16 stored
      n0 = nak_cnt;
      write_run(8'hA0, 20, 0);
      transact(1, 0);
      check_pkt("R13 first", 8'hA0, 8, 0, exp_pid); exp_pid ^= 1'b1;
      transact(1, 0);
      check_pkt("R13 second", 8'hA8, 8, 0, exp_pid); exp_pid ^= 1'b1;
      cap_n = 0;
      pulse_token();
      repeat (8) @(negedge clk);
      chk(nak_cnt == n0 + 1 && cap_n == 0, "R13 extra writes dropped",
          (nak_cnt - n0) * 100 + cap_n, 100);

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule